// File: doc/BRIEF.md
# Edge-Triggered Event Line Controller

This block watches a set of asynchronous event lines and latches a sticky pending flag for a line whenever an enabled edge appears on it. Software chooses, for each line separately, whether a rising edge, a falling edge or both can fire the line. Rising and falling events are recorded in two separate pending registers. Each line drives its own interrupt output, gated by a per-line enable.

Each input first passes through a synchroniser. The synchronised value is then compared with its value one cycle earlier to find edges, so a level that stays high never fires again. Software clears a pending flag by writing a one to it. An edge that lands in the same cycle as a write to the trigger register governing that line's byte lane is discarded.

All registers sit behind a simple 32-bit register port. A write updates only the byte lanes whose strobes are set. Reads are combinational on the address.

Top module: `edge_event_ctrl`

## Requirements
- R1: After reset, the rise-enable, fall-enable, rise-pending, fall-pending and interrupt-enable registers all read 0, and every bit of `irq_o` is low.
- R2: Only lines 20 and 18 to 0 are implemented (`LINE_MASK` = 0x17FFFF). Bit 19 and bits 31 to 21 of every register read 0 and ignore writes. An edge on line 19 never sets a pending flag.
- R3: The registers sit at these offsets: rise-enable 0x000, fall-enable 0x004, rise-pending 0x00C, fall-pending 0x010, interrupt-enable 0x080. A write changes only the byte lanes whose strobe is set: `reg_be[i]` covers data bits 8i+7 to 8i.
- R4: A 0-to-1 transition on a line whose rise-enable bit is 1 sets that line's rise-pending bit. The bit is visible three clock edges after the input changes: two synchroniser edges and one capture edge.
- R5: A 1-to-0 transition on a line whose fall-enable bit is 1 sets that line's fall-pending bit. A line with both enables set records both edges. A transition whose enable bit is 0 changes nothing.
- R6: A line held at a constant level sets no further pending bit once its flag has been cleared.
- R7: `irq_o[i]` is 1 exactly when the line's interrupt-enable bit is 1 and at least one of its rise-pending or fall-pending bits is 1.
- R8: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R9: If an enabled edge on a line occurs in the same cycle as a write of 1 that clears that line's pending bit, the bit stays set.
- R10: An edge that occurs in the cycle in which its own trigger register (rise-enable for rising edges, fall-enable for falling edges) is written with the byte-lane strobe covering that line does not set the pending bit. Lines in unwritten lanes still record their edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lines_in | input | NL | Asynchronous event lines |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | AW | Byte address of the register |
| reg_be | input | 4 | Byte-lane write enables |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_o | output | NL | Per-line interrupt request |

## Verification
The bench uses the default values: 21 lines, the 0x17FFFF implementation mask, a 12-bit address and a two-stage synchroniser. These values place line 19 and line 20 on either side of the hole, and let the interrupt-enable register at 0x080 be decoded. With a two-stage synchroniser, a write can be placed exactly in the cycle in which a detected edge is captured, which makes the write-collision and clear-collision cases reachable.

// File: rtl/edge_event_ctrl.sv
module edge_event_ctrl #(
  parameter int NL = 21,
  parameter logic [NL-1:0] LINE_MASK = 'h17FFFF,
  parameter int AW = 12,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] lines_in,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [3:0]    reg_be,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic [NL-1:0] irq_o
);
  localparam logic [AW-1:0] A_RISE = AW'('h000);
  localparam logic [AW-1:0] A_FALL = AW'('h004);
  localparam logic [AW-1:0] A_RPND = AW'('h00C);
  localparam logic [AW-1:0] A_FPND = AW'('h010);
  localparam logic [AW-1:0] A_MASK = AW'('h080);

  logic [SYNC-1:0][NL-1:0] sync_q;
  logic [NL-1:0] line_s, prev_q;
  logic [NL-1:0] rise_en_q, fall_en_q, rise_pend_q, fall_pend_q, mask_q;

  logic [31:0] lane32;
  logic [NL-1:0] lane_n, wdat_n;
  assign lane32 = {{8{reg_be[3]}}, {8{reg_be[2]}}, {8{reg_be[1]}}, {8{reg_be[0]}}};
  assign lane_n = NL'(lane32) & LINE_MASK;
  assign wdat_n = NL'(reg_wdata);

  logic wr_rise, wr_fall, wr_rpnd, wr_fpnd, wr_mask;
  assign wr_rise = reg_wr && reg_addr == A_RISE;
  assign wr_fall = reg_wr && reg_addr == A_FALL;
  assign wr_rpnd = reg_wr && reg_addr == A_RPND;
  assign wr_fpnd = reg_wr && reg_addr == A_FPND;
  assign wr_mask = reg_wr && reg_addr == A_MASK;

  assign line_s = sync_q[SYNC-1];

  logic [NL-1:0] r_edge, f_edge, r_set, f_set, r_clr, f_clr;
  assign r_edge = line_s & ~prev_q;
  assign f_edge = ~line_s & prev_q;
  assign r_set  = r_edge & rise_en_q & ~(wr_rise ? lane_n : '0);
  assign f_set  = f_edge & fall_en_q & ~(wr_fall ? lane_n : '0);
  assign r_clr  = wr_rpnd ? (wdat_n & lane_n) : '0;
  assign f_clr  = wr_fpnd ? (wdat_n & lane_n) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], lines_in};
      prev_q <= line_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_en_q   <= '0;
      fall_en_q   <= '0;
      mask_q      <= '0;
      rise_pend_q <= '0;
      fall_pend_q <= '0;
    end else begin
      if (wr_rise) rise_en_q <= (rise_en_q & ~lane_n) | (wdat_n & lane_n);
      if (wr_fall) fall_en_q <= (fall_en_q & ~lane_n) | (wdat_n & lane_n);
      if (wr_mask) mask_q    <= (mask_q & ~lane_n) | (wdat_n & lane_n);
      rise_pend_q <= (rise_pend_q & ~r_clr) | r_set;
      fall_pend_q <= (fall_pend_q & ~f_clr) | f_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_RISE:  reg_rdata = 32'(rise_en_q);
      A_FALL:  reg_rdata = 32'(fall_en_q);
      A_RPND:  reg_rdata = 32'(rise_pend_q);
      A_FPND:  reg_rdata = 32'(fall_pend_q);
      A_MASK:  reg_rdata = 32'(mask_q);
      default: reg_rdata = '0;
    endcase
  end

  assign irq_o = (rise_pend_q | fall_pend_q) & mask_q;
endmodule

module edge_event_ctrl_chk #(
  parameter int NL = 21,
  parameter logic [NL-1:0] LINE_MASK = 'h17FFFF,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [3:0]    reg_be,
  input logic [31:0]   reg_wdata,
  input logic [NL-1:0] irq_o,
  input logic [NL-1:0] line_s,
  input logic [NL-1:0] prev_q,
  input logic [NL-1:0] rise_en_q,
  input logic [NL-1:0] fall_en_q,
  input logic [NL-1:0] rise_pend_q,
  input logic [NL-1:0] fall_pend_q,
  input logic [NL-1:0] mask_q
);
  logic [NL-1:0] lanes, rise_wr_lanes, rp_clear;
  assign lanes = NL'({{8{reg_be[3]}}, {8{reg_be[2]}}, {8{reg_be[1]}}, {8{reg_be[0]}}});
  assign rise_wr_lanes = (reg_wr && reg_addr == AW'('h000)) ? lanes : '0;
  assign rp_clear = (reg_wr && reg_addr == AW'('h00C)) ? (NL'(reg_wdata) & lanes) : '0;

  // R2
  reserved_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise_en_q | fall_en_q | rise_pend_q | fall_pend_q | mask_q | irq_o) & ~LINE_MASK) == '0);

  // R6
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_pend_q & ~$past(rise_pend_q) & ~$past(line_s & ~prev_q)) == '0);

  // R10
  rise_wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_pend_q & ~$past(rise_pend_q) & $past(rise_wr_lanes)) == '0);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line_s & ~prev_q & rise_en_q & ~rise_wr_lanes) & ~rise_pend_q) == '0);

  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_pend_q & $past(rp_clear & ~(line_s & ~prev_q))) == '0);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o[0]) |-> mask_q[0]);
endmodule

bind edge_event_ctrl edge_event_ctrl_chk #(.NL(NL), .LINE_MASK(LINE_MASK), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
  .reg_wdata(reg_wdata), .irq_o(irq_o), .line_s(line_s), .prev_q(prev_q),
  .rise_en_q(rise_en_q), .fall_en_q(fall_en_q), .rise_pend_q(rise_pend_q),
  .fall_pend_q(fall_pend_q), .mask_q(mask_q)
);

// File: tb/tb_edge_event_ctrl.sv
module tb_edge_event_ctrl;
  localparam int NL = 21;
  localparam logic [11:0] RISE = 12'h000, FALL = 12'h004, RPND = 12'h00C,
                          FPND = 12'h010, MASK = 12'h080;

  logic clk = 0, rst_n = 0;
  logic [NL-1:0] lines_in = '0;
  logic reg_wr = 0;
  logic [11:0] reg_addr = '0;
  logic [3:0] reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NL-1:0] irq_o;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] q_exp[$];
  bit          q_irq[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  edge_event_ctrl dut (.clk(clk), .rst_n(rst_n), .lines_in(lines_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o));

  always @(posedge clk) begin
    #2;
    if (q_exp.size() > 0) begin
      logic [31:0] e, a;
      bit ir;
      string t;
      e = q_exp.pop_front(); ir = q_irq.pop_front(); t = q_tag.pop_front();
      a = ir ? 32'(irq_o) : reg_rdata;
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic chk(input bit is_irq, input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_addr = a;
    q_exp.push_back(e); q_irq.push_back(is_irq); q_tag.push_back(t);
    do begin @(posedge clk); #3; end while (q_exp.size() != 0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 0; reg_be = '0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // new line value lands so that its detected edge is captured on the write's edge
  task automatic edge_with_write(input logic [NL-1:0] v, input logic [11:0] a,
                                 input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    lines_in = v;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 0; reg_be = '0;
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    chk(0, RISE, 0, "R1 rise-enable reset");
    chk(0, FALL, 0, "R1 fall-enable reset");
    chk(0, RPND, 0, "R1 rise-pending reset");
    chk(0, FPND, 0, "R1 fall-pending reset");
    chk(0, MASK, 0, "R1 irq-enable reset");
    chk(1, 0, 0, "R1 irq reset");
    // R2
    wr(RISE, 32'hFFFF_FFFF, 4'hF);
    chk(0, RISE, 32'h0017_FFFF, "R2 reserved bits");
    // R3
    wr(FALL, 32'hFFFF_FFFF, 4'b0010);
    chk(0, FALL, 32'h0000_FF00, "R3 byte lane");
    // R4
    @(negedge clk); lines_in[9] = 1; settle();
    chk(0, RPND, 32'h200, "R4 rising edge");
    chk(0, FPND, 0, "R4 no falling flag");
    // R5
    @(negedge clk); lines_in[9] = 0; settle();
    chk(0, FPND, 32'h200, "R5 falling edge");
    @(negedge clk); lines_in[0] = 1; settle();
    @(negedge clk); lines_in[0] = 0; settle();
    chk(0, FPND, 32'h200, "R5 disabled falling edge");
    chk(0, RPND, 32'h201, "R4 rising line 0");
    // R8
    wr(RPND, 32'hFFFF_FFFF, 4'hF);
    wr(FPND, 32'hFFFF_FFFF, 4'hF);
    chk(0, RPND, 0, "R8 clear rise");
    chk(0, FPND, 0, "R8 clear fall");
    @(negedge clk); lines_in[5] = 1; settle();
    chk(0, RPND, 32'h20, "R4 line 5");
    wr(RPND, 32'h0, 4'hF);
    chk(0, RPND, 32'h20, "R8 write zero");
    // R6
    wr(RPND, 32'h20, 4'h1);
    repeat (10) @(negedge clk);
    chk(0, RPND, 0, "R6 held level");
    // R7
    @(negedge clk); lines_in[9] = 1; settle();
    chk(1, 0, 0, "R7 masked");
    wr(MASK, 32'h200, 4'hF);
    chk(1, 0, 32'h200, "R7 unmasked rise");
    @(negedge clk); lines_in[9] = 0; settle();
    wr(RPND, 32'h200, 4'hF);
    chk(1, 0, 32'h200, "R7 via fall flag");
    wr(FPND, 32'h200, 4'hF);
    chk(1, 0, 0, "R7 all cleared");
    // R9
    edge_with_write(lines_in | 21'h80, RPND, 32'h80, 4'hF);
    chk(0, RPND, 32'h80, "R9 set beats clear");
    wr(RPND, 32'h80, 4'hF);
    // R10
    edge_with_write(lines_in | 21'h1010, RISE, 32'hFFFF_FFFF, 4'b0001);
    chk(0, RPND, 32'h1000, "R10 rise write blocks lane 0 only");
    edge_with_write(lines_in & ~21'h1000, FALL, 32'hFFFF_FFFF, 4'b0010);
    chk(0, FPND, 0, "R10 fall write blocks");
    // R2
    @(negedge clk); lines_in[19] = 1; settle();
    chk(0, RPND, 32'h1000, "R2 line 19 hole");
    @(negedge clk); lines_in[20] = 1; settle();
    chk(0, RPND, 32'h0010_1000, "R4 line 20");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule